// File: doc/BRIEF.md
# Most-Significant Word and Bit Scanner

This block locates the most significant nonzero 32-bit word of a multi-word vector held in a word-addressed RAM. The caller gives a start pulse, the RAM address of the vector's least significant word and the vector's length in words. The scanner reads the RAM through a synchronous read port that has one cycle of latency. It reads from the top word down and stops at the first word that is not zero.

The result is placed in two 16-bit status words, and a one-cycle done pulse marks the end of the operation. The primary status word carries the RAM word address of the top nonzero word, or a flag that says the whole vector is zero. The secondary status word has two uses. For a plain operation with bit reporting requested, it gives the index of the highest set bit in that top word. For a remainder-producing operation (divide or modulo), it gives the top nonzero word address of a second vector, the remainder, which the block scans after the first.

The secondary word is left untouched for compare-class operations and for plain operations without bit reporting. A bit-reporting request that comes with a remainder or compare operation is dropped.

Top module: `msw_scanner`

## Requirements
- R1: After a scan of a vector with at least one nonzero word, `msw_stat_o[10:0]` holds the RAM address of the highest-addressed nonzero word, and bits 15:11 are 0.
- R2: If every word of the vector is zero, `msw_stat_o` reads 16'h8000: bit 15 set and the address field 0.
- R3: A length of 0 performs no RAM read and reports the zero result of R2. Done is high in the cycle right after the start was sampled.
- R4: The first read is at base+length-1, and each further read is one address lower. The scan stops at the first nonzero word, so the number of reads equals the number of words examined. Take the start-sampling edge as edge 0. If the nonzero word is k words below the top, done is high after edge k+2. For an all-zero vector of L words, done is high after edge L+1.
- R5: With `op_kind_i`=2'b00 (plain) and `ms_one_i`=1, `aux_stat_o` gets `{11'b0, idx}`, where idx is the 5-bit index of the highest set bit of the top nonzero word. For a zero vector it gets 16'h8000.
- R6: With `op_kind_i`=2'b01 (remainder-producing), the remainder vector (`rem_base_i`, `rem_len_i`) is scanned after the main vector. `aux_stat_o` gets its status in the layout of R1 and R2, and `ms_one_i` is ignored. Done comes one edge after the main scan would have ended plus the remainder scan's own latency under R3 and R4.
- R7: With `op_kind_i`=2'b10 or 2'b11 (compare-class), or with plain and `ms_one_i`=0, `aux_stat_o` keeps its previous value.
- R8: Both status words change only on the edge that raises `done_o`. Done is a single-cycle pulse per operation, and both words are 0 after reset.
- R9: A start that arrives while an operation is in progress is ignored and does not change that operation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| base_i | input | 11 | RAM address of the vector's least significant word |
| len_i | input | 9 | Vector length in words |
| rem_base_i | input | 11 | RAM address of the remainder's least significant word |
| rem_len_i | input | 9 | Remainder length in words |
| op_kind_i | input | 2 | 00 plain, 01 remainder-producing, 10/11 compare-class |
| ms_one_i | input | 1 | Request highest-set-bit reporting |
| rd_en_o | output | 1 | RAM read enable |
| rd_addr_o | output | 11 | RAM read word address |
| rd_data_i | input | 32 | RAM read data, valid one cycle after the read |
| msw_stat_o | output | 16 | Primary status: zero flag and top word address |
| aux_stat_o | output | 16 | Secondary status: bit index or remainder status |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after off-by-one errors in the read pipeline:
- **Nonzero word at the top or at the base.** A scanner that samples the wrong cycle's data would report the neighbouring address or stop one word late.
- **Read count against words examined.** A design that keeps issuing reads after a hit, or reads when the length is zero, shows extra reads.
- **Highest set bit at positions 31, 16 and 0.** An inverted or truncated priority search would report the wrong index at these extremes.
- **Secondary word for the remainder and compare paths.** A design that honours a dropped bit-reporting request, or commits the main status before the remainder scan ends, changes the status words early or on the wrong operation.

// File: rtl/msw_scan_pkg.sv
package msw_scan_pkg;
  localparam int STAT_W = 16;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'b00,
    OP_REM   = 2'b01,
    OP_CMP0  = 2'b10,
    OP_CMP1  = 2'b11
  } op_kind_e;

  localparam logic [STAT_W-1:0] STAT_ZERO = 16'h8000;

  // index of the highest set bit; 0 for an all-zero word
  function automatic logic [4:0] top_bit_idx(input logic [31:0] w);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (w[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/msw_scan_engine.sv
module msw_scan_engine #(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              fin_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] hit_addr_o,
  output logic [DATA_W-1:0] hit_word_o
);
  logic              active_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  left_q;
  logic              pend_v_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_last_q;

  // named events for the checks below
  logic fin_len0, fin_scan, word_nz;
  assign word_nz  = pend_v_q && (rd_data_i != '0);
  assign fin_len0 = go_i && (len_i == '0);
  assign fin_scan = pend_v_q && (word_nz || pend_last_q);
  assign fin_o    = fin_len0 || fin_scan;
  assign hit_o    = word_nz;
  assign hit_addr_o = pend_addr_q;
  assign hit_word_o = rd_data_i;

  assign rd_en_o   = active_q && (left_q != '0) && !fin_scan;
  assign rd_addr_o = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      cur_q       <= '0;
      left_q      <= '0;
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_last_q <= 1'b0;
    end else if (go_i && (len_i != '0)) begin
      active_q <= 1'b1;
      cur_q    <= base_i + ADDR_W'(len_i) - ADDR_W'(1);
      left_q   <= len_i;
      pend_v_q <= 1'b0;
    end else if (active_q) begin
      if (fin_scan) begin
        active_q <= 1'b0;
        pend_v_q <= 1'b0;
      end else begin
        pend_v_q <= rd_en_o;
        if (rd_en_o) begin
          pend_addr_q <= cur_q;
          pend_last_q <= (left_q == LEN_W'(1));
          cur_q       <= cur_q - ADDR_W'(1);
          left_q      <= left_q - LEN_W'(1);
        end
      end
    end
  end

  p_len0_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && len_i == '0) |=> !rd_en_o);

  p_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) - ADDR_W'(1)));

  p_pend_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> (pend_addr_q == $past(rd_addr_o)));
endmodule

// File: rtl/msw_bit_locator.sv
module msw_bit_locator #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [15:0]       addr_stat_o,
  output logic [15:0]       bit_stat_o
);
  import msw_scan_pkg::*;
  localparam int PAD_W = STAT_W - ADDR_W;

  always_comb begin
    if (hit_i) begin
      addr_stat_o = {{PAD_W{1'b0}}, addr_i};
      bit_stat_o  = {11'b0, top_bit_idx(word_i[31:0])};
    end else begin
      addr_stat_o = STAT_ZERO;
      bit_stat_o  = STAT_ZERO;
    end
  end
endmodule

// File: rtl/msw_scanner.sv
module msw_scanner #(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] rem_base_i,
  input  logic [LEN_W-1:0]  rem_len_i,
  input  logic [1:0]        op_kind_i,
  input  logic              ms_one_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [15:0]       msw_stat_o,
  output logic [15:0]       aux_stat_o,
  output logic              done_o
);
  import msw_scan_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_VEC, S_GAP, S_REM} state_e;
  state_e state_q;

  op_kind_e          kind_q;
  logic              ms_one_q;
  logic [ADDR_W-1:0] rbase_q;
  logic [LEN_W-1:0]  rlen_q;
  logic [15:0]       vec_hold_q;

  logic              eng_go, eng_fin, eng_hit;
  logic [ADDR_W-1:0] eng_base, eng_hit_addr;
  logic [LEN_W-1:0]  eng_len;
  logic [DATA_W-1:0] eng_word;
  logic [15:0]       addr_stat, bit_stat;

  logic     idle, rem_phase, accept;
  op_kind_e kind_now;
  logic     ms_one_now;
  assign idle       = (state_q == S_IDLE);
  assign rem_phase  = (state_q == S_GAP) || (state_q == S_REM);
  assign accept     = idle && start_i;
  assign kind_now   = idle ? op_kind_e'(op_kind_i) : kind_q;
  assign ms_one_now = idle ? ms_one_i : ms_one_q;

  assign eng_go   = accept || (state_q == S_GAP);
  assign eng_base = idle ? base_i : rbase_q;
  assign eng_len  = idle ? len_i  : rlen_q;

  msw_scan_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .go_i(eng_go), .base_i(eng_base), .len_i(eng_len),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .fin_o(eng_fin), .hit_o(eng_hit), .hit_addr_o(eng_hit_addr), .hit_word_o(eng_word)
  );

  msw_bit_locator #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_locator (
    .hit_i(eng_hit), .addr_i(eng_hit_addr), .word_i(eng_word),
    .addr_stat_o(addr_stat), .bit_stat_o(bit_stat)
  );

  // the phase-finish events, named for the checks
  logic vec_fin, rem_fin;
  assign vec_fin = eng_fin && !rem_phase && (idle ? accept : 1'b1);
  assign rem_fin = eng_fin && rem_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      kind_q     <= OP_PLAIN;
      ms_one_q   <= 1'b0;
      rbase_q    <= '0;
      rlen_q     <= '0;
      vec_hold_q <= '0;
      msw_stat_o <= '0;
      aux_stat_o <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        kind_q   <= op_kind_e'(op_kind_i);
        ms_one_q <= ms_one_i;
        rbase_q  <= rem_base_i;
        rlen_q   <= rem_len_i;
        state_q  <= S_VEC;
      end
      if (state_q == S_GAP) state_q <= S_REM;
      if (vec_fin) begin
        if (kind_now == OP_REM) begin
          vec_hold_q <= addr_stat;
          state_q    <= S_GAP;
        end else begin
          msw_stat_o <= addr_stat;
          if (kind_now == OP_PLAIN && ms_one_now) aux_stat_o <= bit_stat;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
      end
      if (rem_fin) begin
        msw_stat_o <= vec_hold_q;
        aux_stat_o <= addr_stat;
        done_o     <= 1'b1;
        state_q    <= S_IDLE;
      end
    end
  end

  p_msw_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msw_stat_o) |-> done_o);

  p_aux_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_stat_o) |-> done_o);

  p_zero_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msw_stat_o[15] |-> (msw_stat_o[14:0] == '0));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !idle) |=> (rbase_q == $past(rbase_q) && kind_q == $past(kind_q)));

  p_cmp_aux_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_q[1]) |-> $stable(aux_stat_o));
endmodule

// File: tb/msw_scanner_tb_top.sv
module msw_scanner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_i = 0, ms_one_i = 0;
  logic [10:0] base_i = 0, rem_base_i = 0;
  logic [8:0]  len_i = 0, rem_len_i = 0;
  logic [1:0]  op_kind_i = 0;
  logic        rd_en_o, done_o;
  logic [10:0] rd_addr_o;
  logic [31:0] rd_data_i;
  logic [15:0] msw_stat_o, aux_stat_o;

  msw_scanner dut_i (.*);

  // RAM model with one cycle of read latency
  logic [31:0] mem [0:2047];
  int reads = 0;
  always @(posedge clk) if (rd_en_o) begin
    rd_data_i <= mem[rd_addr_o];
    reads <= reads + 1;
  end

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] m_msw = 0, m_aux = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural scan of the model RAM
  task automatic ref_scan(input int b, input int l, output logic [15:0] ast,
                          output logic [15:0] bst, output int lat, output int nrd);
    ast = 16'h8000; bst = 16'h8000; lat = 0; nrd = 0;
    if (l == 0) return;
    lat = l + 1; nrd = l;
    for (int k = 0; k < l; k++) begin
      int a = (b + l - 1 - k) % 2048;
      if (mem[a] != 0) begin
        int idx = 0;
        logic [31:0] w = mem[a];
        while (w > 1) begin w = w >> 1; idx++; end
        ast = 16'(a); bst = 16'(idx); lat = k + 2; nrd = k + 1;
        return;
      end
    end
  endtask

  task automatic run_op(int b, int l, int rb, int rl, bit ms, int kind, string tag, bit poke);
    logic [15:0] va, vb, ra, rbs, e_msw, e_aux;
    int vl, vn, rlat, rn, lat, nrd, r0;
    ref_scan(b, l, va, vb, vl, vn);
    e_msw = va; e_aux = m_aux; lat = vl; nrd = vn;
    if (kind == 0 && ms) e_aux = vb;
    if (kind == 1) begin
      ref_scan(rb, rl, ra, rbs, rlat, rn);
      e_aux = ra; lat = vl + 1 + rlat; nrd = vn + rn;
    end
    r0 = reads;
    base_i = 11'(b); len_i = 9'(l); rem_base_i = 11'(rb); rem_len_i = 9'(rl);
    ms_one_i = ms; op_kind_i = 2'(kind); start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int c = 0; c <= lat + 2; c++) begin
      if (poke && c == 1) begin
        start_i = 1; base_i = 11'd5; len_i = 9'd1; op_kind_i = 2'd0; ms_one_i = 1;
      end else start_i = 0;
      chk(done_o == (c == lat), {tag, " done timing"}, done_o, c == lat);
      chk(msw_stat_o == (c >= lat ? e_msw : m_msw), {tag, " msw"}, msw_stat_o, c >= lat ? e_msw : m_msw);
      chk(aux_stat_o == (c >= lat ? e_aux : m_aux), {tag, " aux"}, aux_stat_o, c >= lat ? e_aux : m_aux);
      @(negedge clk);
    end
    start_i = 0;
    chk(reads - r0 == nrd, {tag, " read count R4"}, reads - r0, nrd);
    m_msw = e_msw; m_aux = e_aux;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(msw_stat_o == 0 && aux_stat_o == 0 && done_o == 0, "R8 reset", msw_stat_o, 0);
    rst_n = 1;
    @(negedge clk);
    mem[107] = 32'h0000_0040;                                  // top of 100..107
    run_op(100, 8, 0, 0, 0, 0, "R1 top word", 0);
    mem[107] = 0; mem[100] = 32'h1;                            // only base word
    run_op(100, 8, 0, 0, 1, 0, "R1 R4 R5 base word bit0", 0);
    run_op(300, 5, 0, 0, 0, 0, "R2 all zero", 0);
    run_op(300, 5, 0, 0, 1, 0, "R2 R5 all zero msone", 0);
    run_op(100, 0, 0, 0, 0, 0, "R3 len zero", 0);
    mem[403] = 32'h0001_2000; mem[401] = 32'hFFFF_FFFF;
    run_op(400, 6, 0, 0, 1, 0, "R5 bit16", 0);
    mem[500] = 32'h8000_0000;
    run_op(500, 1, 0, 0, 1, 0, "R5 bit31", 0);
    run_op(500, 1, 0, 0, 0, 0, "R7 plain no msone", 0);
    mem[602] = 32'h3;
    run_op(400, 6, 600, 4, 1, 1, "R6 remainder", 0);
    run_op(300, 5, 600, 0, 0, 1, "R6 remainder len zero", 0);
    run_op(0, 0, 600, 4, 1, 1, "R6 R3 vector len zero", 0);
    run_op(500, 1, 0, 0, 1, 2, "R7 compare msone ignored", 0);
    run_op(100, 8, 0, 0, 1, 3, "R7 compare 11", 0);
    run_op(300, 5, 0, 0, 1, 0, "R9 start while busy", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog R4 act=%0d exp=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule